// File: doc/BRIEF.md
# Packet Header Protocol Analyzer

This block follows a packet header through its protocol layers as the header arrives on a wide word stream. Each word holds `BYTES` header bytes. Lane 0 (bits 7:0) carries the earliest byte. Inside one clock cycle, a chain of identical byte-step stages walks every byte of the accepted word. Each stage updates the current layer and a small set of variables: the byte count within the current header, the header length, one saved field byte and the nesting depth. Because of this, one word may cross several header boundaries.

For every accepted word the analyzer emits a transition code made of two layers: the layer in force before the word's first byte and the layer reached after its last byte. A downstream field extractor uses this code to choose how to treat the bytes of that word. The output is a Mealy output, because it depends on the registered context and on the current word together. When the word that ends the packet is accepted, a done pulse carries a status: the headers were walked completely, the packet was cut short, or the header was not recognised.

The recognised layers are Ethernet, stacked VLAN tags, MPLS label stacks, IPv4 (including IPv4 carried in IPv4), TCP and UDP. Packets are padded to whole words. Bytes that follow the recognised headers are treated as payload.

Top module: `phpa_top`

## Requirements
- R1: After reset, and on any accepted word flagged start-of-packet, parsing starts from the Ethernet layer with all variables cleared. While no word is accepted, `code_valid` and `done` stay low.
- R2: `in_ready` follows `out_ready`. A word is accepted only when `in_valid` and `out_ready` are both high, and `code_valid` is high exactly for accepted words. A word that is not accepted leaves the parse state unchanged.
- R3: `code` is {layer before the word's first byte, layer after its last byte}, three bits each. The layer encoding is Ethernet 0, VLAN 1, MPLS 2, IPv4 3, TCP 4, UDP 5, payload 6, unknown 7. Lane 0 of `in_data` is processed first.
- R4: The big-endian type field at bytes 12–13 of the Ethernet header, and at bytes 2–3 of each VLAN tag, dispatches the next layer. The value 0x8100 starts another VLAN tag, 0x8847 starts MPLS and 0x0800 starts IPv4. Any other value leads to unknown, which is then kept until the packet ends.
- R5: MPLS labels are 4 bytes long. Bit 0 of a label's third byte marks the bottom of the stack. A label with that bit set leads to IPv4, and a label without it leads to another label.
- R6: The low nibble of the first IPv4 byte, times four, gives the IPv4 header length in bytes. The following layer starts right after that many bytes. A nibble below 5 leads to unknown.
- R7: The IPv4 protocol byte (header byte 9) selects the next layer once the header ends. The value 4 starts an inner IPv4 header, 6 starts TCP and 17 starts UDP. Any other value leads to unknown.
- R8: A UDP header is 8 bytes. A TCP header is four times the high nibble of its byte 12 long, and a value below 5 leads to unknown. Once the layer-4 header ends, the state is payload.
- R9: Every VLAN tag, MPLS label and IPv4 header entered adds one nesting level. Entering one more when `MAX_NEST` levels are already in use leads to unknown instead.
- R10: `done` pulses with the accepted end-of-packet word. `done_status` is 0 when payload was reached, 1 when the packet ended inside a known header, and 2 when the state is unknown. The next word then starts from Ethernet, even without a start flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word can be taken |
| in_data | input | 8*BYTES | Header bytes; lane 0 first |
| in_sop | input | 1 | Word is the first of a packet |
| in_eop | input | 1 | Word is the last of a packet |
| out_ready | input | 1 | Downstream extractor can take a code |
| code_valid | output | 1 | Transition code valid (word accepted) |
| code | output | 6 | {start layer, end layer} for this word |
| done | output | 1 | End-of-packet pulse |
| done_status | output | 2 | 0 complete, 1 truncated, 2 unknown |

## Verification
The code, `code_valid`, `done` and `done_status` all belong to the word currently presented. They are due in the same cycle the word is accepted, with no register in between. The effect of that word on the parse context shows up only in the code of the next accepted word. The bench therefore drives each word just after a falling edge and reads the outputs two nanoseconds later, before the rising edge that commits the word. Stall and restart effects are judged through the code of the word that follows them.

// File: rtl/phpa_pkg.sv
package phpa_pkg;

    localparam int NEST_W = 4;
    localparam int CNT_W  = 6;

    typedef enum logic [2:0] {
        L_ETH  = 3'd0,
        L_VLAN = 3'd1,
        L_MPLS = 3'd2,
        L_IPV4 = 3'd3,
        L_TCP  = 3'd4,
        L_UDP  = 3'd5,
        L_PAY  = 3'd6,
        L_UNK  = 3'd7
    } layer_e;

    typedef enum logic [1:0] {
        ST_OK    = 2'd0,
        ST_TRUNC = 2'd1,
        ST_UNK   = 2'd2
    } stat_e;

    // Parse context: layer plus the variable registers of the machine
    typedef struct packed {
        layer_e             layer;
        logic [CNT_W-1:0]   cnt;    // byte index inside current header
        logic [CNT_W-1:0]   hlen;   // variable header length in bytes
        logic [7:0]         save;   // saved field byte (type high / S bit / protocol)
        logic [NEST_W-1:0]  depth;  // encapsulation levels in use
    } ctx_t;

    localparam ctx_t CTX_INIT = '{layer: L_ETH, cnt: '0, hlen: '0, save: '0, depth: '0};

    localparam logic [15:0] TYPE_VLAN = 16'h8100;
    localparam logic [15:0] TYPE_MPLS = 16'h8847;
    localparam logic [15:0] TYPE_IPV4 = 16'h0800;
    localparam logic [7:0]  PROTO_IPIP = 8'd4;
    localparam logic [7:0]  PROTO_TCP  = 8'd6;
    localparam logic [7:0]  PROTO_UDP  = 8'd17;

    localparam logic [CNT_W-1:0] ETH_TYPE_HI = CNT_W'(12);
    localparam logic [CNT_W-1:0] ETH_TYPE_LO = CNT_W'(13);
    localparam logic [CNT_W-1:0] TAG_HI      = CNT_W'(2);
    localparam logic [CNT_W-1:0] TAG_LO      = CNT_W'(3);
    localparam logic [CNT_W-1:0] IP_PROTO    = CNT_W'(9);
    localparam logic [CNT_W-1:0] TCP_OFF     = CNT_W'(12);
    localparam logic [CNT_W-1:0] UDP_LAST    = CNT_W'(7);

    // Enter an encapsulation level, or give up when the nesting budget is spent
    function automatic ctx_t push_level(ctx_t c, layer_e nxt, logic [NEST_W-1:0] lim);
        ctx_t n;
        n     = c;
        n.cnt = '0;
        if (c.depth >= lim) begin
            n.layer = L_UNK;
        end else begin
            n.layer = nxt;
            n.depth = c.depth + 1'b1;
        end
        return n;
    endfunction

    function automatic ctx_t enter_l4(ctx_t c, layer_e nxt);
        ctx_t n;
        n       = c;
        n.cnt   = '0;
        n.layer = nxt;
        return n;
    endfunction

    function automatic ctx_t by_type(ctx_t c, logic [15:0] tval, logic [NEST_W-1:0] lim);
        ctx_t n;
        case (tval)
            TYPE_VLAN: n = push_level(c, L_VLAN, lim);
            TYPE_MPLS: n = push_level(c, L_MPLS, lim);
            TYPE_IPV4: n = push_level(c, L_IPV4, lim);
            default: begin
                n       = c;
                n.layer = L_UNK;
            end
        endcase
        return n;
    endfunction

    function automatic ctx_t by_proto(ctx_t c, logic [7:0] p, logic [NEST_W-1:0] lim);
        ctx_t n;
        case (p)
            PROTO_IPIP: n = push_level(c, L_IPV4, lim);
            PROTO_TCP:  n = enter_l4(c, L_TCP);
            PROTO_UDP:  n = enter_l4(c, L_UDP);
            default: begin
                n       = c;
                n.layer = L_UNK;
            end
        endcase
        return n;
    endfunction

    // One byte of the Mealy machine: (context, byte) -> next context
    function automatic ctx_t step_byte(ctx_t c, logic [7:0] b, logic [NEST_W-1:0] lim);
        ctx_t n;
        n     = c;
        n.cnt = c.cnt + 1'b1;
        case (c.layer)
            L_ETH: begin
                if (c.cnt == ETH_TYPE_HI) n.save = b;
                if (c.cnt == ETH_TYPE_LO) n = by_type(c, {c.save, b}, lim);
            end
            L_VLAN: begin
                if (c.cnt == TAG_HI) n.save = b;
                if (c.cnt == TAG_LO) n = by_type(c, {c.save, b}, lim);
            end
            L_MPLS: begin
                if (c.cnt == TAG_HI) n.save = b;
                if (c.cnt == TAG_LO) begin
                    if (c.save[0]) n = push_level(c, L_IPV4, lim);
                    else           n = push_level(c, L_MPLS, lim);
                end
            end
            L_IPV4: begin
                if (c.cnt == '0) begin
                    n.hlen = {b[3:0], 2'b00};
                    if (b[3:0] < 4'd5) n.layer = L_UNK;
                end else begin
                    if (c.cnt == IP_PROTO) n.save = b;
                    if (c.cnt == c.hlen - 1'b1) n = by_proto(c, c.save, lim);
                end
            end
            L_TCP: begin
                if (c.cnt == TCP_OFF) begin
                    n.hlen = {b[7:4], 2'b00};
                    if (b[7:4] < 4'd5) n.layer = L_UNK;
                end else if (c.cnt > TCP_OFF && c.cnt == c.hlen - 1'b1) begin
                    n.layer = L_PAY;
                    n.cnt   = c.cnt;
                end
            end
            L_UDP: begin
                if (c.cnt == UDP_LAST) begin
                    n.layer = L_PAY;
                    n.cnt   = c.cnt;
                end
            end
            default: begin
                n.cnt = c.cnt;
            end
        endcase
        return n;
    endfunction

endpackage

// File: rtl/phpa_byte_step.sv
module phpa_byte_step
    import phpa_pkg::*;
#(
    parameter int MAX_NEST = 8
) (
    input  ctx_t       ctx_i,
    input  logic [7:0] byte_i,
    output ctx_t       ctx_o
);

    localparam logic [NEST_W-1:0] LIM = NEST_W'(MAX_NEST);

    always_comb begin
        ctx_o = step_byte(ctx_i, byte_i, LIM);
    end

endmodule

// File: rtl/phpa_word_chain.sv
module phpa_word_chain
    import phpa_pkg::*;
#(
    parameter int BYTES    = 8,
    parameter int MAX_NEST = 8
) (
    input  ctx_t               start_i,
    input  logic [8*BYTES-1:0] data_i,
    output ctx_t               fin_o
);

    ctx_t chain [BYTES+1];

    assign chain[0] = start_i;

    for (genvar g = 0; g < BYTES; g++) begin : g_lane
        phpa_byte_step #(
            .MAX_NEST (MAX_NEST)
        ) u_step (
            .ctx_i  (chain[g]),
            .byte_i (data_i[8*g +: 8]),
            .ctx_o  (chain[g+1])
        );
    end

    assign fin_o = chain[BYTES];

endmodule

// File: rtl/phpa_top.sv
module phpa_top
    import phpa_pkg::*;
#(
    parameter int BYTES    = 8,
    parameter int MAX_NEST = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [8*BYTES-1:0] in_data,
    input  logic               in_sop,
    input  logic               in_eop,
    input  logic               out_ready,
    output logic               code_valid,
    output logic [5:0]         code,
    output logic               done,
    output logic [1:0]         done_status
);

    localparam int DW = 8 * BYTES;

    ctx_t ctx_q, ctx_d;
    ctx_t start_ctx, fin_ctx;
    logic acc;
    logic [DW-1:0] word;

    assign word = in_data;

    phpa_word_chain #(
        .BYTES    (BYTES),
        .MAX_NEST (MAX_NEST)
    ) u_chain (
        .start_i (start_ctx),
        .data_i  (word),
        .fin_o   (fin_ctx)
    );

    always_comb begin
        acc       = in_valid && out_ready;
        start_ctx = in_sop ? CTX_INIT : ctx_q;
        ctx_d     = ctx_q;
        if (acc) begin
            ctx_d = in_eop ? CTX_INIT : fin_ctx;
        end

        in_ready   = out_ready;
        code_valid = acc;
        code       = {start_ctx.layer, fin_ctx.layer};
        done       = acc && in_eop;
        case (fin_ctx.layer)
            L_PAY:   done_status = ST_OK;
            L_UNK:   done_status = ST_UNK;
            default: done_status = ST_TRUNC;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctx_q <= CTX_INIT;
        else        ctx_q <= ctx_d;
    end

    // R2
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && out_ready) |=> $stable(ctx_q));

    // R10
    eop_rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && out_ready && in_eop) |=> (ctx_q == CTX_INIT));

    // R1
    sop_from_eth_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (code_valid && in_sop) |-> (code[5:3] == L_ETH));

    // R9
    nest_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_q.depth <= NEST_W'(MAX_NEST));

    // R4
    unknown_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && out_ready && !in_sop && !in_eop && ctx_q.layer == L_UNK)
        |=> (ctx_q.layer == L_UNK));

    // R10
    ok_is_payload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_status == ST_OK) |-> (code[2:0] == L_PAY));

endmodule

// File: tb/test_phpa_top.sv
module test_phpa_top;

    localparam int BYTES = 8;
    localparam int DW    = 8 * BYTES;

    typedef struct packed {
        logic [3:0]  nvlan;
        logic [3:0]  nmpls;
        logic [15:0] etype;
        logic [1:0]  tunnel;
        logic [3:0]  ihl;
        logic [7:0]  proto;
        logic [3:0]  doff;
        logic [4:0]  words;
        logic [4:0]  cidx;
        logic [5:0]  ccode;
        logic [5:0]  lcode;
        logic [1:0]  stat;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t TBL [NV] = '{
        '{4'd0, 4'd0, 16'h0800, 2'd0, 4'd5, 8'd6,  4'd5, 5'd7,  5'd1, 6'd3,  6'd38, 2'd0},
        '{4'd0, 4'd0, 16'h0800, 2'd0, 4'd5, 8'd17, 4'd5, 5'd6,  5'd4, 6'd29, 6'd46, 2'd0},
        '{4'd2, 4'd0, 16'h0800, 2'd0, 4'd5, 8'd17, 4'd5, 5'd7,  5'd2, 6'd11, 6'd46, 2'd0},
        '{4'd0, 4'd2, 16'h0000, 2'd0, 4'd5, 8'd6,  4'd5, 5'd8,  5'd2, 6'd19, 6'd38, 2'd0},
        '{4'd0, 4'd0, 16'h0800, 2'd1, 4'd5, 8'd6,  4'd5, 5'd10, 5'd4, 6'd27, 6'd38, 2'd0},
        '{4'd0, 4'd0, 16'h0800, 2'd0, 4'd7, 8'd17, 4'd5, 5'd7,  5'd5, 6'd29, 6'd46, 2'd0},
        '{4'd0, 4'd0, 16'h86DD, 2'd0, 4'd5, 8'd6,  4'd5, 5'd2,  5'd1, 6'd7,  6'd7,  2'd2},
        '{4'd0, 4'd0, 16'h0800, 2'd0, 4'd5, 8'd1,  4'd5, 5'd5,  5'd4, 6'd31, 6'd31, 2'd2},
        '{4'd0, 4'd0, 16'h0800, 2'd0, 4'd5, 8'd6,  4'd5, 5'd4,  5'd1, 6'd3,  6'd27, 2'd1},
        '{4'd0, 4'd0, 16'h0800, 2'd0, 4'd4, 8'd6,  4'd5, 5'd2,  5'd1, 6'd7,  6'd7,  2'd2},
        '{4'd8, 4'd0, 16'h0800, 2'd0, 4'd5, 8'd17, 4'd5, 5'd6,  5'd5, 6'd15, 6'd15, 2'd2},
        '{4'd7, 4'd0, 16'h0800, 2'd0, 4'd5, 8'd17, 4'd5, 5'd9,  5'd5, 6'd11, 6'd46, 2'd0},
        '{4'd0, 4'd0, 16'h0800, 2'd0, 4'd5, 8'd6,  4'd6, 5'd8,  5'd6, 6'd36, 6'd38, 2'd0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic          in_valid = 1'b0;
    logic          in_sop = 1'b0;
    logic          in_eop = 1'b0;
    logic          out_ready = 1'b1;
    logic [DW-1:0] in_data = '0;
    logic          in_ready, code_valid, done;
    logic [5:0]    code;
    logic [1:0]    done_status;

    phpa_top #(.BYTES(BYTES), .MAX_NEST(8)) i_phpa_top (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_ready    (in_ready),
        .in_data     (in_data),
        .in_sop      (in_sop),
        .in_eop      (in_eop),
        .out_ready   (out_ready),
        .code_valid  (code_valid),
        .code        (code),
        .done        (done),
        .done_status (done_status)
    );

    int n_chk = 0;
    int n_bad = 0;

    logic [7:0] pkt      [128];
    logic [5:0] got_code [32];
    logic       got_done [32];
    logic       got_cv   [32];
    logic [1:0] got_stat [32];

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic string tag_of(input int i);
        case (i)
            0: return "R3";
            1: return "R8";
            2: return "R4";
            3: return "R5";
            4: return "R7";
            5: return "R6";
            6: return "R4";
            7: return "R7";
            8: return "R10";
            9: return "R6";
            10: return "R9";
            11: return "R9";
            default: return "R8";
        endcase
    endfunction

    task automatic put16(input int p, input logic [15:0] v);
        pkt[p]   = v[15:8];
        pkt[p+1] = v[7:0];
    endtask

    task automatic build(input vec_t v);
        int pos;
        for (int i = 0; i < 128; i++) pkt[i] = 8'h00;
        pos = 12;
        for (int t = 0; t < int'(v.nvlan); t++) begin
            put16(pos, 16'h8100);
            pos += 4;
        end
        if (v.nmpls != 0) begin
            put16(pos, 16'h8847);
            pos += 2;
            for (int m = 0; m < int'(v.nmpls); m++) begin
                pkt[pos+2] = (m == int'(v.nmpls) - 1) ? 8'h01 : 8'h00;
                pos += 4;
            end
        end else begin
            put16(pos, v.etype);
            pos += 2;
        end
        for (int t = 0; t <= int'(v.tunnel); t++) begin
            pkt[pos]   = {4'h4, v.ihl};
            pkt[pos+9] = (t < int'(v.tunnel)) ? 8'd4 : v.proto;
            pos += 4 * int'(v.ihl);
        end
        pkt[pos+12] = {v.doff, 4'h0};
    endtask

    task automatic send_word(input int w, input bit sop, input bit eop);
        @(negedge clk);
        in_valid = 1'b1;
        in_sop   = sop;
        in_eop   = eop;
        for (int k = 0; k < BYTES; k++) in_data[8*k +: 8] = pkt[w*BYTES + k];
        #2;
        got_cv[w]   = code_valid;
        got_code[w] = code;
        got_done[w] = done;
        got_stat[w] = done_status;
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        in_sop   = 1'b0;
        in_eop   = 1'b0;
    endtask

    task automatic send_pkt(input int words, input bit with_sop);
        for (int w = 0; w < words; w++) send_word(w, with_sop && (w == 0), w == words - 1);
    endtask

    initial begin
        #2_000_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state, nothing accepted
        repeat (3) @(posedge clk);
        #2;
        chk("R1 code_valid in reset", int'(code_valid), 0);
        chk("R1 done in reset", int'(done), 0);
        @(negedge clk);
        rst_n = 1'b1;
        #2;
        chk("R1 code_valid idle", int'(code_valid), 0);
        out_ready = 1'b0;
        #1;
        chk("R2 in_ready follows out_ready low", int'(in_ready), 0);
        out_ready = 1'b1;
        #1;
        chk("R2 in_ready follows out_ready high", int'(in_ready), 1);

        // Table of packets
        for (int i = 0; i < NV; i++) begin
            int bad_early;
            int nw;
            build(TBL[i]);
            nw = int'(TBL[i].words);
            send_pkt(nw, 1'b1);
            chk({tag_of(i), " mid-word code"}, int'(got_code[TBL[i].cidx]), int'(TBL[i].ccode));
            chk({tag_of(i), " last-word code"}, int'(got_code[nw-1]), int'(TBL[i].lcode));
            chk("R10 done status", int'(got_stat[nw-1]), int'(TBL[i].stat));
            bad_early = 0;
            for (int w = 0; w < nw; w++) begin
                if (got_cv[w] !== 1'b1) bad_early++;
                if (w < nw - 1 && got_done[w] !== 1'b0) bad_early++;
                if (w == nw - 1 && got_done[w] !== 1'b1) bad_early++;
            end
            chk("R10 done only at eop, R2 code_valid per word", bad_early, 0);
        end

        // R2: stall between words keeps the context
        build(TBL[0]);
        send_word(0, 1'b1, 1'b0);
        @(negedge clk);
        out_ready = 1'b0;
        in_valid  = 1'b1;
        for (int k = 0; k < BYTES; k++) in_data[8*k +: 8] = pkt[BYTES + k];
        #2;
        chk("R2 no code while stalled", int'(code_valid), 0);
        chk("R2 no done while stalled", int'(done), 0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        out_ready = 1'b1;
        #2;
        chk("R2 code after stall", int'(code), 3);
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        for (int w = 2; w < 7; w++) send_word(w, 1'b0, w == 6);
        chk("R2 last code after stall", int'(got_code[6]), 38);

        // R1: start flag mid-packet restarts parsing
        build(TBL[2]);
        send_word(0, 1'b1, 1'b0);
        send_word(1, 1'b0, 1'b0);
        build(TBL[0]);
        send_pkt(7, 1'b1);
        chk("R1 restart word0 code", int'(got_code[0]), 0);
        chk("R1 restart word1 code", int'(got_code[1]), 3);

        // R10: word after eop starts at Ethernet without a start flag
        build(TBL[1]);
        send_pkt(6, 1'b1);
        build(TBL[0]);
        send_pkt(7, 1'b0);
        chk("R10 post-eop word1 code", int'(got_code[1]), 3);
        chk("R10 post-eop last code", int'(got_code[6]), 38);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule